// File: doc/BRIEF.md
# Allocation Size Immediate Decoder

This block expands a compact size code, taken from an instruction immediate, into a 64-bit byte count for an allocator. Two codes are supported. The fine code is an 8-bit value with a 3-bit exponent and a 5-bit mantissa. It gives byte-exact sizes for small requests, and a coarser step for larger ones, up to 4032 bytes. The coarse code is a 5-bit value that names a power of two starting at 4 KB. It picks up where the fine code stops and reaches 8 TB.

A one-bit mode input chooses which code drives the result. The decode itself is pure wiring plus one multiplexer per format. By default, a result register captures the decoded size on any clock edge where the input strobe is high. It raises a valid flag in the following cycle. With the register parameter cleared, the block becomes fully combinational.

Top module: `alloc_size_dec`

## Requirements
- R1: In fine mode (`mode_sel` = 0), when exponent bits `fine_imm[7:5]` are 0, the size equals the mantissa `fine_imm[4:0]` with no implicit bit (0 to 31).
- R2: In fine mode, when the exponent E is 1 to 7, the size equals (32 + mantissa) multiplied by 2^(E−1).
- R3: A fine-mode result never has a bit set above bit 11. The largest fine size is 4032 (code 8'hFF).
- R4: In coarse mode (`mode_sel` = 1), the size equals 2^(`coarse_imm` + 12). Exactly one bit is set, at position 12 to 43. Code 0 gives 4096 and code 31 gives 2^43.
- R5: The immediate of the format not selected by `mode_sel` has no effect on the result.
- R6: With `REGISTERED` = 1, `size_bytes` is loaded only on a rising edge where `in_valid` is 1. It holds its value on every other edge.
- R7: `size_valid` equals the value `in_valid` had at the previous rising edge.
- R8: A synchronous active-high `rst` clears `size_bytes` to 0 and `size_valid` to 0 at the next rising edge.
- R9: The 256 fine codes decode to strictly increasing sizes when taken in code order, so no two codes share a value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the result register |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe: capture the decoded size at this edge |
| mode_sel | input | 1 | 0 selects the fine code, 1 selects the coarse code |
| fine_imm | input | 8 | Fine code: exponent [7:5], mantissa [4:0] |
| coarse_imm | input | 5 | Coarse code: power-of-two index biased by 12 |
| size_bytes | output | 64 | Decoded size in bytes, zero-extended |
| size_valid | output | 1 | High in the cycle after a captured strobe |

## Verification
The bound checker watches several properties on every cycle:
- the strobe-to-flag delay, and that the result holds whenever no strobe is present;
- the clearing effect of reset;
- the bit-range limits of each format: no bits above 11 for fine codes, and one set bit within 12 to 43 for coarse codes.

The exact arithmetic value of each code cannot be shown by those range properties. Nor can the strict ordering across all 256 fine codes, or the insensitivity to the unselected immediate. Those come only from the bench. It sweeps every code of both formats against its own reference arithmetic, while toggling the unused field.

// File: rtl/alloc_size_pkg.sv
package alloc_size_pkg;

  typedef enum logic {
    SZ_MODE_FINE   = 1'b0,
    SZ_MODE_COARSE = 1'b1
  } size_mode_e;

  localparam int FINE_EXP_W   = 3;
  localparam int FINE_MANT_W  = 5;
  localparam int COARSE_W     = 5;
  localparam int COARSE_BIAS  = 12;
  localparam int SIZE_W       = 64;

endpackage

// File: rtl/fine_size_dec.sv
// Fine code: exponent selects one of 2**EXP_W statically shifted copies of
// the mantissa (with hidden bit for nonzero exponents).
module fine_size_dec #(
  parameter int EXP_W  = 3,
  parameter int MANT_W = 5,
  parameter int OUT_W  = 64
) (
  input  logic [EXP_W+MANT_W-1:0] code,
  output logic [OUT_W-1:0]        size
);
  localparam int NUM_EXP = 2 ** EXP_W;
  localparam int BASE_W  = MANT_W + 1;
  localparam int SPAN_W  = BASE_W + NUM_EXP - 2;

  logic [EXP_W-1:0]  expo;
  logic [MANT_W-1:0] mant;
  logic [SPAN_W-1:0] lane [NUM_EXP];

  assign expo = code[EXP_W+MANT_W-1:MANT_W];
  assign mant = code[MANT_W-1:0];

  for (genvar e = 0; e < NUM_EXP; e++) begin : g_lane
    if (e == 0) begin : g_sub
      assign lane[e] = SPAN_W'(mant);
    end else begin : g_norm
      assign lane[e] = SPAN_W'({1'b1, mant}) << (e - 1);
    end
  end

  assign size = OUT_W'(lane[expo]);

endmodule

// File: rtl/coarse_size_dec.sv
// Coarse code: one-hot power of two, index offset by BIAS.
module coarse_size_dec #(
  parameter int IDX_W = 5,
  parameter int BIAS  = 12,
  parameter int OUT_W = 64
) (
  input  logic [IDX_W-1:0] code,
  output logic [OUT_W-1:0] size
);
  localparam int NUM_IDX = 2 ** IDX_W;

  for (genvar k = 0; k < OUT_W; k++) begin : g_bit
    if (k >= BIAS && k < BIAS + NUM_IDX) begin : g_live
      assign size[k] = (code == IDX_W'(k - BIAS));
    end else begin : g_dead
      assign size[k] = 1'b0;
    end
  end

endmodule

// File: rtl/size_out_stage.sv
// Optional capture register for the decoded size.
module size_out_stage #(
  parameter int OUT_W      = 64,
  parameter bit REGISTERED = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [OUT_W-1:0] d,
  output logic [OUT_W-1:0] q,
  output logic             q_valid
);
  if (REGISTERED) begin : g_reg
    logic [OUT_W-1:0] q_r;
    logic             v_r;
    always_ff @(posedge clk) begin
      if (rst) begin
        q_r <= '0;
        v_r <= 1'b0;
      end else begin
        v_r <= in_valid;
        if (in_valid) q_r <= d;
      end
    end
    assign q       = q_r;
    assign q_valid = v_r;
  end else begin : g_comb
    assign q       = d;
    assign q_valid = in_valid;
  end

endmodule

// File: rtl/alloc_size_dec.sv
module alloc_size_dec
  import alloc_size_pkg::*;
#(
  parameter int EXP_W      = FINE_EXP_W,
  parameter int MANT_W     = FINE_MANT_W,
  parameter int IDX_W      = COARSE_W,
  parameter int BIAS       = COARSE_BIAS,
  parameter int OUT_W      = SIZE_W,
  parameter bit REGISTERED = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic                    mode_sel,
  input  logic [EXP_W+MANT_W-1:0] fine_imm,
  input  logic [IDX_W-1:0]        coarse_imm,
  output logic [OUT_W-1:0]        size_bytes,
  output logic                    size_valid
);
  logic [OUT_W-1:0] fine_size;
  logic [OUT_W-1:0] coarse_size;
  logic [OUT_W-1:0] picked;
  size_mode_e       mode;

  assign mode = size_mode_e'(mode_sel);

  fine_size_dec #(.EXP_W(EXP_W), .MANT_W(MANT_W), .OUT_W(OUT_W)) u_fine (
    .code (fine_imm),
    .size (fine_size)
  );

  coarse_size_dec #(.IDX_W(IDX_W), .BIAS(BIAS), .OUT_W(OUT_W)) u_coarse (
    .code (coarse_imm),
    .size (coarse_size)
  );

  always_comb begin
    picked = (mode == SZ_MODE_COARSE) ? coarse_size : fine_size;
  end

  size_out_stage #(.OUT_W(OUT_W), .REGISTERED(REGISTERED)) u_out (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .d        (picked),
    .q        (size_bytes),
    .q_valid  (size_valid)
  );

endmodule

// File: rtl/alloc_size_dec_chk.sv
module alloc_size_dec_chk #(
  parameter int OUT_W      = 64,
  parameter int BIAS       = 12,
  parameter int IDX_W      = 5,
  parameter bit REGISTERED = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             mode_sel,
  input logic [OUT_W-1:0] size_bytes,
  input logic             size_valid
);
  localparam int TOP_BIT = BIAS + (2 ** IDX_W) - 1;

  if (REGISTERED) begin : g_chk
    logic rst_seen = 1'b0;
    always_ff @(posedge clk) rst_seen <= rst;

    // R8
    always @(negedge clk) begin
      if (rst_seen) begin
        rst_clear_chk: assert (size_bytes == '0 && !size_valid);
      end
    end

    // R7
    strobe_to_flag_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> size_valid);

    // R7
    idle_flag_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !size_valid);

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(size_bytes));

    // R3
    fine_range_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !mode_sel) |=> (size_bytes[OUT_W-1:12] == '0));

    // R4
    coarse_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && mode_sel) |=>
        ($countones(size_bytes) == 1 && size_bytes[BIAS-1:0] == '0
         && size_bytes[OUT_W-1:TOP_BIT+1] == '0));
  end

endmodule

bind alloc_size_dec alloc_size_dec_chk #(
  .OUT_W(OUT_W), .BIAS(BIAS), .IDX_W(IDX_W), .REGISTERED(REGISTERED)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .mode_sel   (mode_sel),
  .size_bytes (size_bytes),
  .size_valid (size_valid)
);

// File: tb/alloc_size_dec_tb.sv
module alloc_size_dec_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        mode_sel = 1'b0;
  logic [7:0]  fine_imm = '0;
  logic [4:0]  coarse_imm = '0;
  logic [63:0] size_bytes;
  logic        size_valid;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  alloc_size_dec u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode_sel(mode_sel),
    .fine_imm(fine_imm), .coarse_imm(coarse_imm),
    .size_bytes(size_bytes), .size_valid(size_valid)
  );

  function automatic logic [63:0] fine_ref(input logic [7:0] c);
    int e = int'(c[7:5]);
    longint unsigned m = longint'(c[4:0]);
    longint unsigned v;
    if (e == 0) return m;
    v = 32 + m;
    for (int i = 1; i < e; i++) v = v * 2;
    return v;
  endfunction

  function automatic logic [63:0] coarse_ref(input logic [4:0] c);
    longint unsigned v = 4096;
    for (int i = 0; i < int'(c); i++) v = v * 2;
    return v;
  endfunction

  task automatic check64(input string req, input logic [63:0] act,
                         input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one strobed request, sample one cycle later
  task automatic issue(input logic m, input logic [7:0] f, input logic [4:0] c);
    @(negedge clk);
    in_valid = 1'b1; mode_sel = m; fine_imm = f; coarse_imm = c;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset_state();
    check64("R8 reset size", size_bytes, 64'd0);
    check64("R8 reset flag", {63'd0, size_valid}, 64'd1 - 64'd1);
  endtask

  task automatic t_fine_sweep();
    logic [63:0] prev = '0;
    for (int k = 0; k < 256; k++) begin
      issue(1'b0, 8'(k), 5'(k * 7 + 3));
      if (k < 32) check64("R1 subnormal", size_bytes, fine_ref(8'(k)));
      else        check64("R2 normal", size_bytes, fine_ref(8'(k)));
      check64("R5 fine ignores coarse", size_bytes, fine_ref(8'(k)));
      check64("R3 upper bits", {12'd0, size_bytes[63:12]}, 64'd0);
      check64("R7 flag", {63'd0, size_valid}, 64'd1);
      if (k > 0) check64("R9 increasing", {63'd0, size_bytes > prev}, 64'd1);
      prev = size_bytes;
    end
  endtask

  task automatic t_fine_corners();
    issue(1'b0, 8'hFF, 5'd31);
    check64("R3 max", size_bytes, 64'd4032);
    issue(1'b0, 8'h00, 5'd31);
    check64("R1 zero", size_bytes, 64'd0);
    issue(1'b0, 8'h20, 5'd0);
    check64("R2 first normal", size_bytes, 64'd32);
    issue(1'b0, 8'hE0, 5'd9);
    check64("R2 top exp base", size_bytes, 64'd2048);
  endtask

  task automatic t_coarse_sweep();
    for (int k = 0; k < 32; k++) begin
      issue(1'b1, 8'(k * 37 + 5), 5'(k));
      check64("R4 coarse", size_bytes, coarse_ref(5'(k)));
      check64("R5 coarse ignores fine", size_bytes, coarse_ref(5'(k)));
    end
    issue(1'b1, 8'hFF, 5'd0);
    check64("R4 min 4096", size_bytes, 64'd4096);
    issue(1'b1, 8'h00, 5'd31);
    check64("R4 max 2^43", size_bytes, 64'h0000_0800_0000_0000);
  endtask

  task automatic t_hold();
    logic [63:0] held;
    issue(1'b0, 8'h7B, 5'd2);
    held = size_bytes;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      in_valid = 1'b0; mode_sel = 1'(k); fine_imm = 8'(k + 200); coarse_imm = 5'(k + 20);
      @(negedge clk);
      check64("R6 hold without strobe", size_bytes, held);
      check64("R7 flag low", {63'd0, size_valid}, 64'd0);
    end
  endtask

  task automatic t_flag_pulse();
    @(negedge clk);
    in_valid = 1'b1; mode_sel = 1'b1; coarse_imm = 5'd3;
    @(negedge clk);
    in_valid = 1'b0;
    check64("R7 pulse high", {63'd0, size_valid}, 64'd1);
    check64("R6 captured", size_bytes, 64'd32768);
    @(negedge clk);
    check64("R7 pulse ends", {63'd0, size_valid}, 64'd0);
  endtask

  task automatic t_mid_reset();
    issue(1'b1, 8'd0, 5'd10);
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    check64("R8 reset clears size", size_bytes, 64'd0);
    check64("R8 reset clears flag", {63'd0, size_valid}, 64'd0);
    rst = 1'b0; in_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst = 1'b0;
    t_fine_sweep();
    t_fine_corners();
    t_coarse_sweep();
    t_hold();
    t_flag_pulse();
    t_mid_reset();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule